// File: doc/BRIEF.md
# Select-Framed Serial Slave Port

This block is the slave end of a four-wire serial link with an eight-bit frame. An external master supplies the serial clock, an active-low select and the incoming data line. The block returns a byte on its outgoing data line at the same time. All three pad inputs are brought into the system clock domain through two-flop synchronizers. Clock edges are then detected in that domain, so the shift logic is ordinary synchronous logic.

Software places a byte in the data register before the master starts. The block shifts that byte out most significant bit first while it shifts in the master's byte. After the eighth sampled bit, the received byte goes to a holding buffer and a done flag is raised. An interrupt can be raised from that flag. Software clears the flag in two steps. First it reads the status register while the flag is set. Then it either reads or writes the data register.

The clock phase setting decides how select frames each byte. With phase 0, the first bit appears on the output as soon as select falls, and select must return high between bytes before a new byte can be loaded. With phase 1, the first bit is driven on the first clock edge, and select may stay low across back-to-back bytes.

Top module: `spi_sel_slave`

Register map (regAddr):
- 0: data. A write loads the transmit byte. A read returns the last received byte.
- 1: status. Bit 7 is the done flag. All other bits read 0.
- 2: control. Bit 0 is enable, bit 1 is master-select, bit 2 is interrupt enable, bit 3 is clock polarity and bit 4 is clock phase.

## Requirements
- R1: The port takes part in a transfer only when control bit 0 (enable) is 1 and control bit 1 (master-select) is 0. Otherwise misoOe stays low and no transfer sets the done flag.
- R2: A data write loads the transmit byte. With phase 0, its bit 7 is on misoOut once select is low, and the remaining bits follow most significant first.
- R3: Bits on mosiIn are taken most significant first, one per sampling edge. After the eighth bit, a read of address 0 returns the received byte.
- R4: With phase 1, select may stay low across consecutive bytes and every byte completes. Each bit, starting with bit 7, is driven on the leading clock edge of its bit period.
- R5: With phase 0, a data write made while select is low is ignored, so the next byte sends the previous shift contents (0x00 once a byte has been fully shifted out).
- R6: The done flag (status bit 7) rises after the eighth sampling edge. irqOut is 1 exactly when the flag is 1, control bit 2 is 1 and intMask is 0.
- R7: The flag clears only after a status read made while it is set, followed by a data read or a data write. A data write in that second step also loads the transmit byte.
- R8: While the flag is set and the status register has not yet been read, data writes are ignored.
- R9: While select is high, misoOe is low and a partly received byte is discarded. The next full byte is received and transmitted correctly, and the aborted byte does not set the flag.
- R10: Both clock polarities work in both phases. With polarity 1 the clock idles high and the leading edge is falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select (0 data, 1 status, 2 control) |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| intMask | input | 1 | External interrupt mask, 1 blocks irqOut |
| irqOut | output | 1 | Transfer-done interrupt request |
| sckIn | input | 1 | Serial clock from the master |
| ssNIn | input | 1 | Active-low slave select |
| mosiIn | input | 1 | Serial data from the master |
| misoOut | output | 1 | Serial data to the master |
| misoOe | output | 1 | Output enable for misoOut |

## Verification
The bench goes after several corner cases.
- Phase 0 writes made while select is low, and data writes made while the flag is set but before the status read. A design that accepted either would transmit the rejected byte instead of 0x00.
- Select held low across two phase-1 bytes. A design that needed a select pulse would never finish the second byte, or would misalign its first bit.
- A byte aborted after three bits by select rising. Without a counter reset, the next byte would be received shifted and the flag would rise early.
- Both flag-clear paths, the interrupt mask, and all four clock modes, with random data. An inverted polarity or phase decode would corrupt the bytes in both directions.

// File: rtl/spiss_pkg.sv
package spiss_pkg;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  // Strobes from the control module to the datapath, one system clock wide.
  typedef struct packed {
    logic loadTx;     // copy the write data into the transmit shifter
    logic sampleBit;  // take mosiBit into the receive shifter
    logic shiftBit;   // advance the transmit shifter
    logic captureRx;  // last bit of the byte: move it into the buffer
    logic frameIdle;  // select inactive or port disabled
    logic mosiBit;    // synchronized incoming data bit
  } spiss_strobe_t;

endpackage

// File: rtl/spiss_datapath.sv
module spiss_datapath
  import spiss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiss_strobe_t     strobe,
  input  logic              cpha,
  input  logic [DATA_W-1:0] loadData,
  output logic              misoBit,
  output logic [DATA_W-1:0] rxBuf
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic              misoReg;

  // Transmit shifter. In phase 1 the bit is moved to a register on the
  // leading edge, which puts bit 7 on the line at the first edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      misoReg <= 1'b0;
    end else if (strobe.loadTx) begin
      txShift <= loadData;
    end else if (strobe.shiftBit) begin
      if (cpha) misoReg <= txShift[MSB];
      txShift <= {txShift[MSB-1:0], 1'b0};
    end
  end

  // Receive shifter and holding buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxBuf   <= '0;
    end else begin
      if (strobe.frameIdle) rxShift <= '0;
      else if (strobe.sampleBit) rxShift <= {rxShift[MSB-1:0], strobe.mosiBit};
      if (strobe.captureRx) rxBuf <= {rxShift[MSB-1:0], strobe.mosiBit};
    end
  end

  assign misoBit = cpha ? misoReg : txShift[MSB];

  // R3: the buffer changes only when a byte completes
  a_r3_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureRx |=> $stable(rxBuf));

  // R2: the shifter never moves without a load or a shift edge
  a_r2_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadTx && !strobe.shiftBit |=> $stable(txShift));

endmodule

// File: rtl/spiss_ctrl.sv
module spiss_ctrl
  import spiss_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [4:0]        ctrlWdata,
  input  logic [DATA_W-1:0] rxBuf,
  output logic [DATA_W-1:0] regRdata,
  input  logic              intMask,
  output logic              irqOut,
  input  logic              sckIn,
  input  logic              ssNIn,
  input  logic              mosiIn,
  output logic              misoOe,
  output logic              cphaOut,
  output spiss_strobe_t     strobe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  // Synchronizers and edge detection
  logic [SYNC_STAGES-1:0] sckPipe, ssPipe, mosiPipe;
  logic sckLast;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe  <= '0;
      ssPipe   <= '1;
      mosiPipe <= '0;
      sckLast  <= 1'b0;
    end else begin
      sckPipe  <= {sckPipe[SYNC_STAGES-2:0], sckIn};
      ssPipe   <= {ssPipe[SYNC_STAGES-2:0], ssNIn};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosiIn};
      sckLast  <= sckPipe[SYNC_STAGES-1];
    end
  end

  logic sckS, ssS, mosiS;
  assign sckS  = sckPipe[SYNC_STAGES-1];
  assign ssS   = ssPipe[SYNC_STAGES-1];
  assign mosiS = mosiPipe[SYNC_STAGES-1];

  // Control register
  logic enBit, mstBit, ieBit, cpolBit, cphaBit;
  logic dataWr, dataRd, statRd, ctrlWr;
  assign dataWr = regWr && (regAddr == ADDR_DATA);
  assign dataRd = regRd && (regAddr == ADDR_DATA);
  assign statRd = regRd && (regAddr == ADDR_STAT);
  assign ctrlWr = regWr && (regAddr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) {cphaBit, cpolBit, ieBit, mstBit, enBit} <= '0;
    else if (ctrlWr) {cphaBit, cpolBit, ieBit, mstBit, enBit} <= ctrlWdata;
  end

  logic active, selected;
  assign active   = enBit && !mstBit;
  assign selected = active && !ssS;

  logic sckRise, sckFall, leadEdge, trailEdge, sampleEdge, shiftEdge;
  assign sckRise    = sckS && !sckLast;
  assign sckFall    = !sckS && sckLast;
  assign leadEdge   = cpolBit ? sckFall : sckRise;
  assign trailEdge  = cpolBit ? sckRise : sckFall;
  assign sampleEdge = selected && (cphaBit ? trailEdge : leadEdge);
  assign shiftEdge  = selected && (cphaBit ? leadEdge : trailEdge);

  // Bit counter
  logic [CNT_W-1:0] bitCnt;
  logic lastBit;
  assign lastBit = sampleEdge && (bitCnt == LAST_BIT);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (!selected) bitCnt <= '0;
    else if (sampleEdge) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
  end

  // Done flag and two-step clear
  logic doneFlag, statSeen, wrAllowed, loadOk;
  assign wrAllowed = !doneFlag || statSeen;
  assign loadOk    = dataWr && wrAllowed && (bitCnt == '0) && (cphaBit || ssS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      statSeen <= 1'b0;
    end else if (lastBit) begin
      doneFlag <= 1'b1;
      statSeen <= 1'b0;
    end else if (doneFlag && statSeen && (dataWr || dataRd)) begin
      doneFlag <= 1'b0;
      statSeen <= 1'b0;
    end else if (doneFlag && statRd) begin
      statSeen <= 1'b1;
    end
  end

  always_comb begin
    strobe.loadTx    = loadOk;
    strobe.sampleBit = sampleEdge;
    strobe.shiftBit  = shiftEdge;
    strobe.captureRx = lastBit;
    strobe.frameIdle = !selected;
    strobe.mosiBit   = mosiS;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_DATA: regRdata = rxBuf;
      ADDR_STAT: regRdata = {doneFlag, {(DATA_W-1){1'b0}}};
      ADDR_CTRL: regRdata = {{(DATA_W-5){1'b0}}, cphaBit, cpolBit, ieBit, mstBit, enBit};
      default:   regRdata = '0;
    endcase
  end

  assign irqOut  = doneFlag && ieBit && !intMask;
  assign misoOe  = selected;
  assign cphaOut = cphaBit;

  // R6: a completed byte raises the flag on the next cycle
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    lastBit |=> doneFlag);
  // R6: no interrupt without the flag
  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> doneFlag);
  // R7: second step of the clear sequence drops the flag
  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && statSeen && (dataWr || dataRd) && !lastBit |=> !doneFlag);
  // R8: no load while the flag waits for its status read
  a_r8_wr_blocked: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !statSeen |-> !strobe.loadTx);
  // R9: select high returns the bit counter to zero
  a_r9_cnt_idle: assert property (@(posedge clk) disable iff (!rstN)
    ssS |=> bitCnt == '0);
  // R1: a disabled port never drives the line
  a_r1_oe_gate: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !misoOe);

endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
  import spiss_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              intMask,
  output logic              irqOut,
  input  logic              sckIn,
  input  logic              ssNIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe
);

  spiss_strobe_t     strobe;
  logic              cpha;
  logic [DATA_W-1:0] rxBuf;

  spiss_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .ctrlWdata(regWdata[4:0]), .rxBuf(rxBuf), .regRdata(regRdata),
    .intMask(intMask), .irqOut(irqOut), .sckIn(sckIn), .ssNIn(ssNIn),
    .mosiIn(mosiIn), .misoOe(misoOe), .cphaOut(cpha), .strobe(strobe)
  );

  spiss_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpha(cpha),
    .loadData(regWdata), .misoBit(misoOut), .rxBuf(rxBuf)
  );

endmodule

// File: tb/spi_sel_slave_bench.sv
module spi_sel_slave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic intMask = 1'b0;
  logic irqOut;
  logic sckIn = 1'b0, ssNIn = 1'b1, mosiIn = 1'b0;
  logic misoOut, misoOe;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic lastOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sel_slave u_spi_sel_slave (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .intMask(intMask), .irqOut(irqOut),
    .sckIn(sckIn), .ssNIn(ssNIn), .mosiIn(mosiIn), .misoOut(misoOut), .misoOe(misoOe)
  );

  function automatic logic expIrq(input logic flag, input logic ie, input logic mask);
    return flag && ie && !mask;
  endfunction

  function automatic logic [7:0] ctrlWord(input bit en, input bit mst, input bit ie,
                                          input bit cpol, input bit cpha);
    return {3'b000, cpha, cpol, ie, mst, en};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  logic curCpol = 1'b0;
  logic curCpha = 1'b0;

  task automatic configure(input bit en, input bit mst, input bit ie,
                           input bit cpol, input bit cpha);
    sckIn = cpol;
    curCpol = cpol; curCpha = cpha;
    regWrite(2'd2, ctrlWord(en, mst, ie, cpol, cpha));
    idle(4);
  endtask

  // Master side of one frame; nbits below 8 aborts the byte
  task automatic xfer(input logic [7:0] mo, input int nbits, input bit keepSel,
                      output logic [7:0] mi);
    mi = '0;
    if (ssNIn) begin
      ssNIn = 1'b0;
      idle(HALF);
    end
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!curCpha) begin
        mosiIn = mo[i];
        idle(HALF);
        mi[i] = misoOut;
        if (i == 7) lastOe = misoOe;
        sckIn = ~curCpol;
        idle(HALF);
        sckIn = curCpol;
      end else begin
        sckIn = ~curCpol;
        mosiIn = mo[i];
        idle(HALF);
        mi[i] = misoOut;
        if (i == 7) lastOe = misoOe;
        sckIn = curCpol;
        idle(HALF);
      end
    end
    idle(HALF);
    if (!keepSel) begin
      ssNIn = 1'b1;
      idle(HALF);
    end
  endtask

  task automatic clearByRead();
    logic [7:0] d;
    regRead(2'd1, d);
    regRead(2'd0, d);
  endtask

  initial begin
    logic [7:0] d, mi, tx, rx;
    void'($urandom(32'd4621));
    idle(3);
    rstN = 1'b1;
    idle(3);

    // Reset state
    regRead(2'd1, d);   check("R6 reset flag", d, 8'h00);
    check("R9 reset oe", {7'b0, misoOe}, 8'h00);
    check("R6 reset irq", {7'b0, irqOut}, 8'h00);

    // Phase 0, polarity 0, basic frame
    configure(1, 0, 1, 0, 0);
    regWrite(2'd0, 8'hA5);
    xfer(8'h3C, 8, 0, mi);
    check("R2 tx byte", mi, 8'hA5);
    check("R1 oe enabled", {7'b0, lastOe}, 8'h01);
    check("R6 irq raised", {7'b0, irqOut}, {7'b0, expIrq(1'b1, 1'b1, 1'b0)});
    regRead(2'd1, d);   check("R6 flag set", d, 8'h80);
    regRead(2'd0, d);   check("R3 rx byte", d, 8'h3C);
    regRead(2'd1, d);   check("R7 cleared by read", d, 8'h00);

    // Interrupt mask and the write path of the clear
    regWrite(2'd0, 8'h11);
    xfer(8'h00, 8, 0, mi);
    intMask = 1'b1; idle(1);
    check("R6 irq masked", {7'b0, irqOut}, {7'b0, expIrq(1'b1, 1'b1, 1'b1)});
    intMask = 1'b0; idle(1);
    check("R6 irq unmasked", {7'b0, irqOut}, 8'h01);
    regRead(2'd1, d);
    regWrite(2'd0, 8'h22);
    regRead(2'd1, d);   check("R7 cleared by write", d, 8'h00);
    xfer(8'h5C, 8, 0, mi);
    check("R7 write loaded", mi, 8'h22);

    // Write while flag set and status unread is ignored
    regWrite(2'd0, 8'h3C);
    clearByRead();
    xfer(8'h01, 8, 0, mi);
    check("R8 blocked write", mi, 8'h00);
    clearByRead();

    // Phase 0: write while select low is ignored
    ssNIn = 1'b0; idle(HALF);
    regWrite(2'd0, 8'h77);
    xfer(8'h02, 8, 0, mi);
    check("R5 write during select", mi, 8'h00);
    clearByRead();

    // Aborted byte
    regWrite(2'd0, 8'h81);
    xfer(8'hFF, 3, 0, mi);
    check("R9 aborted oe", {7'b0, misoOe}, 8'h00);
    regRead(2'd1, d);   check("R9 abort no flag", d, 8'h00);
    regWrite(2'd0, 8'h5A);
    xfer(8'hC3, 8, 0, mi);
    check("R9 tx after abort", mi, 8'h5A);
    regRead(2'd1, d);
    regRead(2'd0, d);   check("R9 rx after abort", d, 8'hC3);

    // Phase 1, select held low across two bytes
    configure(1, 0, 1, 0, 1);
    regWrite(2'd0, 8'h96);
    xfer(8'h69, 8, 1, mi);
    check("R4 first byte", mi, 8'h96);
    regRead(2'd1, d);   check("R4 first flag", d, 8'h80);
    regWrite(2'd0, 8'hF0);
    check("R4 select held", {7'b0, ssNIn}, 8'h00);
    xfer(8'h0F, 8, 0, mi);
    check("R4 second byte", mi, 8'hF0);
    regRead(2'd1, d);   check("R4 second flag", d, 8'h80);
    regRead(2'd0, d);   check("R4 second rx", d, 8'h0F);

    // Random data in all four modes
    for (int m = 0; m < 4; m++) begin
      configure(1, 0, 0, m[1], m[0]);
      for (int k = 0; k < 12; k++) begin
        tx = 8'($urandom);
        rx = 8'($urandom);
        regWrite(2'd0, tx);
        xfer(rx, 8, 0, mi);
        check("R10 random tx", mi, tx);
        check("R6 irq disabled", {7'b0, irqOut}, {7'b0, expIrq(1'b1, 1'b0, 1'b0)});
        regRead(2'd1, d);   check("R6 random flag", d, 8'h80);
        regRead(2'd0, d);   check("R10 random rx", d, rx);
      end
    end

    // Disabled and master-selected configurations
    configure(0, 0, 1, 0, 0);
    regWrite(2'd0, 8'h55);
    xfer(8'hAA, 8, 0, mi);
    check("R1 disabled oe", {7'b0, lastOe}, 8'h00);
    regRead(2'd1, d);   check("R1 disabled flag", d, 8'h00);
    configure(1, 1, 1, 0, 0);
    xfer(8'hAA, 8, 0, mi);
    check("R1 master oe", {7'b0, lastOe}, 8'h00);
    regRead(2'd1, d);   check("R1 master flag", d, 8'h00);
    check("R1 master irq", {7'b0, irqOut}, 8'h00);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule